// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit executes the 32-bit bit-manipulation operations of a RISC-V core: address-generation shift-and-add, the basic bit-manipulation group (counts, extensions, rotates, byte operations, min/max, inverted logic) and the single-bit group. It takes the raw fields of an instruction (major opcode, funct3, funct7 and the 5-bit rs2/shamt field) plus two operands. The first operand is the rs1 value. The second is either the rs2 value or the immediate. It returns a result and a flag that marks whether the field pattern is a supported encoding.

Decoding does not stop at funct3. funct7 picks the operation inside each funct3 group. For the unary group (immediate opcode, funct3=001, funct7=0110000), and for OR-combine, byte reverse and halfword zero-extend, the 5-bit rs2/shamt field also acts as a sub-opcode. Bit positions and rotate amounts come from the low 5 bits of the second operand. The outputs are registered, so a result appears one clock after its inputs are presented.

Top module: `bitmanip_exec`

## Requirements
- R1: Immediate opcode 0010011, funct3=001: funct7 0010100 sets, 0100100 clears and 0110100 inverts bit b[4:0] of operand a. The valid flag is 1.
- R2: Register opcode 0110011, funct3=001: funct7 0010100 sets, 0100100 clears and 0110100 inverts bit b[4:0] of a. funct7=0100100 with funct3=101 extracts bit b[4:0] of a in both opcodes. The extracted bit goes to result bit 0 and every other result bit is 0.
- R3: Opcode 0010011, funct3=001, funct7=0110000 uses the rs2/shamt field as a sub-opcode. 00000 gives leading-zero count, 00001 gives trailing-zero count and 00010 gives population count. Both zero counts return 32 for a zero operand, and population count of all-ones returns 32.
- R4: Under the same prefix as R3, field 00100 sign-extends byte 0 of a and field 00101 sign-extends halfword 0 of a. Opcode 0110011, funct3=100, funct7=0000100 with field 00000 zero-extends halfword 0 of a.
- R5: Rotates use the amount b[4:0]. Rotate-left is opcode 0110011, funct3=001, funct7=0110000. Rotate-right is funct3=101, funct7=0110000 in either opcode. An amount of zero returns a unchanged.
- R6: Opcode 0010011, funct3=101 handles two byte operations. funct7=0010100 with field 00111 sets each result byte to 0xFF if any bit of that byte of a is set, and to 0x00 otherwise. funct7=0110100 with field 11000 reverses the byte order of a.
- R7: Opcode 0110011, funct7=0000101: funct3 100 gives the signed minimum, 101 the unsigned minimum, 110 the signed maximum and 111 the unsigned maximum of a and b.
- R8: Opcode 0110011, funct7=0010000: funct3 010, 100 and 110 return (a shifted left by 1, 2 and 3) + b, modulo 2^32.
- R9: Opcode 0110011, funct7=0100000: funct3 100 returns ~(a^b), 110 returns a|~b and 111 returns a&~b.
- R10: Any other combination of opcode, funct3, funct7 and field gives result 0 with the valid flag 0.
- R11: The result and the valid flag update one clock after the inputs. While reset is high they hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_major | input | 7 | Major opcode field |
| in_fn3 | input | 3 | funct3 field |
| in_fn7 | input | 7 | funct7 field |
| in_sel5 | input | 5 | rs2/shamt field, used as a sub-opcode by some encodings |
| in_a | input | 32 | First operand (rs1 value) |
| in_b | input | 32 | Second operand (rs2 value or immediate) |
| out_result | output | 32 | Registered result |
| out_valid | output | 1 | Registered flag: the encoding was a supported operation |

## Verification
A wrong decode shows up at the ports one clock later. The same field pattern yields the wrong result, or the valid flag goes the wrong way. For that reason the bench sweeps every funct3 and funct7 value against several sub-opcode fields, under the two real opcodes and one unsupported one. A fault in the count, rotate or byte logic shows only for particular operands. Each supported encoding is therefore run against edge operands: zero, all-ones, a lone sign bit, and amounts with junk in the upper bits. It is also run against a spread of pseudo-random pairs. Any reset fault is visible in the first sampled cycle.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam logic [6:0] MAJ_IMM = 7'b0010011;
  localparam logic [6:0] MAJ_REG = 7'b0110011;

  typedef enum logic [4:0] {
    OP_NONE, OP_BSET, OP_BCLR, OP_BINV, OP_BEXT,
    OP_CLZ, OP_CTZ, OP_CPOP, OP_SEXTB, OP_SEXTH, OP_ZEXTH,
    OP_ROL, OP_ROR, OP_ORCB, OP_REV8,
    OP_MIN, OP_MINU, OP_MAX, OP_MAXU,
    OP_SH1ADD, OP_SH2ADD, OP_SH3ADD,
    OP_XNOR, OP_ORN, OP_ANDN
  } bm_op_e;
endpackage

// File: rtl/bm_decode.sv
module bm_decode
  import bm_pkg::*;
(
  input  logic [6:0] major,
  input  logic [2:0] fn3,
  input  logic [6:0] fn7,
  input  logic [4:0] sel5,
  output bm_op_e     op
);
  always_comb begin
    op = OP_NONE;
    if (major == MAJ_IMM) begin
      case (fn3)
        3'b001: begin
          case (fn7)
            7'b0010100: op = OP_BSET;
            7'b0100100: op = OP_BCLR;
            7'b0110100: op = OP_BINV;
            7'b0110000: begin
              case (sel5)
                5'b00000: op = OP_CLZ;
                5'b00001: op = OP_CTZ;
                5'b00010: op = OP_CPOP;
                5'b00100: op = OP_SEXTB;
                5'b00101: op = OP_SEXTH;
                default:  op = OP_NONE;
              endcase
            end
            default: op = OP_NONE;
          endcase
        end
        3'b101: begin
          case (fn7)
            7'b0100100: op = OP_BEXT;
            7'b0110000: op = OP_ROR;
            7'b0010100: op = (sel5 == 5'b00111) ? OP_ORCB : OP_NONE;
            7'b0110100: op = (sel5 == 5'b11000) ? OP_REV8 : OP_NONE;
            default:    op = OP_NONE;
          endcase
        end
        default: op = OP_NONE;
      endcase
    end else if (major == MAJ_REG) begin
      case (fn3)
        3'b001: begin
          case (fn7)
            7'b0010100: op = OP_BSET;
            7'b0100100: op = OP_BCLR;
            7'b0110000: op = OP_ROL;
            7'b0110100: op = OP_BINV;
            default:    op = OP_NONE;
          endcase
        end
        3'b010: op = (fn7 == 7'b0010000) ? OP_SH1ADD : OP_NONE;
        3'b100: begin
          case (fn7)
            7'b0010000: op = OP_SH2ADD;
            7'b0000101: op = OP_MIN;
            7'b0100000: op = OP_XNOR;
            7'b0000100: op = (sel5 == 5'b00000) ? OP_ZEXTH : OP_NONE;
            default:    op = OP_NONE;
          endcase
        end
        3'b101: begin
          case (fn7)
            7'b0000101: op = OP_MINU;
            7'b0100100: op = OP_BEXT;
            7'b0110000: op = OP_ROR;
            default:    op = OP_NONE;
          endcase
        end
        3'b110: begin
          case (fn7)
            7'b0010000: op = OP_SH3ADD;
            7'b0000101: op = OP_MAX;
            7'b0100000: op = OP_ORN;
            default:    op = OP_NONE;
          endcase
        end
        3'b111: begin
          case (fn7)
            7'b0000101: op = OP_MAXU;
            7'b0100000: op = OP_ANDN;
            default:    op = OP_NONE;
          endcase
        end
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bm_bitcount.sv
module bm_bitcount #(
  parameter int W = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] lead_z,
  output logic [CW-1:0] trail_z,
  output logic [CW-1:0] ones
);
  always_comb begin
    logic hit_hi, hit_lo;
    lead_z  = '0;
    trail_z = '0;
    ones    = '0;
    hit_hi  = 1'b0;
    hit_lo  = 1'b0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(val[i]);
      if (!hit_hi) begin
        if (val[W-1-i]) hit_hi = 1'b1;
        else            lead_z = lead_z + 1'b1;
      end
      if (!hit_lo) begin
        if (val[i]) hit_lo = 1'b1;
        else        trail_z = trail_z + 1'b1;
      end
    end
  end

  always_comb begin
    AST_COUNT_BOUND: assert (lead_z <= CW'(W) && trail_z <= CW'(W) && ones <= CW'(W)); // R3
  end
endmodule

// File: rtl/bm_alu.sv
module bm_alu
  import bm_pkg::*;
#(
  parameter int W = 32
) (
  input  bm_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int IW = $clog2(W);
  localparam int CW = IW + 1;
  localparam int NB = W / 8;

  logic [CW-1:0] lz, tz, pc;
  logic [IW-1:0] amt;
  logic [CW-1:0] amt_inv;
  logic [W-1:0]  mask, rot_l, rot_r, orc, rev;
  logic          lt_s, lt_u;

  bm_bitcount #(.W(W)) u_cnt (.val(a), .lead_z(lz), .trail_z(tz), .ones(pc));

  assign amt     = b[IW-1:0];
  assign amt_inv = CW'(W) - {1'b0, amt};
  assign mask    = {{(W-1){1'b0}}, 1'b1} << amt;
  assign rot_l   = (a << amt) | (a >> amt_inv);
  assign rot_r   = (a >> amt) | (a << amt_inv);
  assign lt_s    = $signed(a) < $signed(b);
  assign lt_u    = a < b;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign orc[g*8 +: 8] = (|a[g*8 +: 8]) ? 8'hFF : 8'h00;
    assign rev[g*8 +: 8] = a[(NB-1-g)*8 +: 8];
  end

  always_comb begin
    case (op)
      OP_BSET:   res = a | mask;
      OP_BCLR:   res = a & ~mask;
      OP_BINV:   res = a ^ mask;
      OP_BEXT:   res = {{(W-1){1'b0}}, a[amt]};
      OP_CLZ:    res = {{(W-CW){1'b0}}, lz};
      OP_CTZ:    res = {{(W-CW){1'b0}}, tz};
      OP_CPOP:   res = {{(W-CW){1'b0}}, pc};
      OP_SEXTB:  res = {{(W-8){a[7]}}, a[7:0]};
      OP_SEXTH:  res = {{(W-16){a[15]}}, a[15:0]};
      OP_ZEXTH:  res = {{(W-16){1'b0}}, a[15:0]};
      OP_ROL:    res = rot_l;
      OP_ROR:    res = rot_r;
      OP_ORCB:   res = orc;
      OP_REV8:   res = rev;
      OP_MIN:    res = lt_s ? a : b;
      OP_MINU:   res = lt_u ? a : b;
      OP_MAX:    res = lt_s ? b : a;
      OP_MAXU:   res = lt_u ? b : a;
      OP_SH1ADD: res = (a << 1) + b;
      OP_SH2ADD: res = (a << 2) + b;
      OP_SH3ADD: res = (a << 3) + b;
      OP_XNOR:   res = ~(a ^ b);
      OP_ORN:    res = a | ~b;
      OP_ANDN:   res = a & ~b;
      default:   res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_ROL || op == OP_ROR)
      AST_ROT_POPCOUNT: assert ($countones(res) == $countones(a)); // R5
  end
endmodule

// File: rtl/bitmanip_exec.sv
module bitmanip_exec
  import bm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [6:0]   in_major,
  input  logic [2:0]   in_fn3,
  input  logic [6:0]   in_fn7,
  input  logic [4:0]   in_sel5,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_result,
  output logic         out_valid
);
  localparam int NB = W / 8;

  bm_op_e       op_d, op_q;
  logic [W-1:0] res_d;

  bm_decode u_dec (
    .major(in_major), .fn3(in_fn3), .fn7(in_fn7), .sel5(in_sel5), .op(op_d)
  );

  bm_alu #(.W(W)) u_alu (.op(op_d), .a(in_a), .b(in_b), .res(res_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result <= '0;
      out_valid  <= 1'b0;
      op_q       <= OP_NONE;
    end else begin
      out_result <= res_d;
      out_valid  <= (op_d != OP_NONE);
      op_q       <= op_d;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (!out_valid && out_result == '0)); // R11
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst) !out_valid |-> out_result == '0); // R10
  AST_EXTRACT_ONEBIT: assert property (@(posedge clk) disable iff (rst)
    op_q == OP_BEXT |-> out_result[W-1:1] == '0); // R2
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_CLZ || op_q == OP_CTZ || op_q == OP_CPOP) |-> out_result <= W); // R3
  AST_MINU_BOUND: assert property (@(posedge clk) disable iff (rst)
    op_q == OP_MINU |-> (out_result <= $past(in_a) && out_result <= $past(in_b))); // R7
  AST_REV8_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    op_q == OP_REV8 |-> $countones(out_result) == $countones($past(in_a))); // R6

  for (genvar g = 0; g < NB; g++) begin : g_orc_chk
    AST_ORCB_BYTE: assert property (@(posedge clk) disable iff (rst)
      op_q == OP_ORCB |-> (out_result[g*8 +: 8] == 8'h00 || out_result[g*8 +: 8] == 8'hFF)); // R6
  end
endmodule

// File: tb/tb_bitmanip_exec.sv
`timescale 1ns/1ps
module tb_bitmanip_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  in_major = '0;
  logic [2:0]  in_fn3 = '0;
  logic [6:0]  in_fn7 = '0;
  logic [4:0]  in_sel5 = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [31:0] out_result;
  logic        out_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitmanip_exec dut (.*);

  function automatic logic [32:0] ref_model(input logic [6:0] opc, input logic [2:0] f3,
      input logic [6:0] f7, input logic [4:0] fl, input logic [31:0] a, input logic [31:0] b,
      output string tag);
    int n; logic [31:0] r; logic v; int k;
    n = int'(b[4:0]); r = 32'h0; v = 1'b1; tag = "R10";
    if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0010100) begin tag = "R1"; r = a; r[n] = 1'b1; end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0100100) begin tag = "R1"; r = a; r[n] = 1'b0; end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0110100) begin tag = "R1"; r = a; r[n] = ~a[n]; end
    else if (opc == 7'b0110011 && f3 == 3'b001 && f7 == 7'b0010100) begin tag = "R2"; r = a; r[n] = 1'b1; end
    else if (opc == 7'b0110011 && f3 == 3'b001 && f7 == 7'b0100100) begin tag = "R2"; r = a; r[n] = 1'b0; end
    else if (opc == 7'b0110011 && f3 == 3'b001 && f7 == 7'b0110100) begin tag = "R2"; r = a; r[n] = ~a[n]; end
    else if ((opc == 7'b0110011 || opc == 7'b0010011) && f3 == 3'b101 && f7 == 7'b0100100) begin tag = "R2"; r = {31'h0, a[n]}; end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0110000 && fl == 5'd0) begin
      tag = "R3"; k = 31; while (k >= 0 && !a[k]) k--; r = 32'(31 - k); end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0110000 && fl == 5'd1) begin
      tag = "R3"; k = 0; while (k < 32 && !a[k]) k++; r = 32'(k); end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0110000 && fl == 5'd2) begin
      tag = "R3"; for (int i = 0; i < 32; i++) r = r + 32'(a[i]); end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0110000 && fl == 5'd4) begin
      tag = "R4"; r = 32'($signed(a[7:0])); end
    else if (opc == 7'b0010011 && f3 == 3'b001 && f7 == 7'b0110000 && fl == 5'd5) begin
      tag = "R4"; r = 32'($signed(a[15:0])); end
    else if (opc == 7'b0110011 && f3 == 3'b100 && f7 == 7'b0000100 && fl == 5'd0) begin
      tag = "R4"; r = a & 32'h0000FFFF; end
    else if (opc == 7'b0110011 && f3 == 3'b001 && f7 == 7'b0110000) begin
      tag = "R5"; r = a; for (int i = 0; i < n; i++) r = {r[30:0], r[31]}; end
    else if ((opc == 7'b0110011 || opc == 7'b0010011) && f3 == 3'b101 && f7 == 7'b0110000) begin
      tag = "R5"; r = a; for (int i = 0; i < n; i++) r = {r[0], r[31:1]}; end
    else if (opc == 7'b0010011 && f3 == 3'b101 && f7 == 7'b0010100 && fl == 5'd7) begin
      tag = "R6"; for (int i = 0; i < 4; i++) if (((a >> (8*i)) & 32'hFF) != 0) r = r | (32'hFF << (8*i)); end
    else if (opc == 7'b0010011 && f3 == 3'b101 && f7 == 7'b0110100 && fl == 5'd24) begin
      tag = "R6"; r = {a[7:0], a[15:8], a[23:16], a[31:24]}; end
    else if (opc == 7'b0110011 && f7 == 7'b0000101 && f3[2]) begin
      tag = "R7";
      case (f3[1:0])
        2'd0: r = ($signed(a) < $signed(b)) ? a : b;
        2'd1: r = (a < b) ? a : b;
        2'd2: r = ($signed(a) > $signed(b)) ? a : b;
        default: r = (a > b) ? a : b;
      endcase end
    else if (opc == 7'b0110011 && f7 == 7'b0010000 && (f3 == 3'b010 || f3 == 3'b100 || f3 == 3'b110)) begin
      tag = "R8"; r = a * (32'd1 << f3[2:1]) + b; end
    else if (opc == 7'b0110011 && f7 == 7'b0100000 && f3 == 3'b100) begin tag = "R9"; r = ~(a ^ b); end
    else if (opc == 7'b0110011 && f7 == 7'b0100000 && f3 == 3'b110) begin tag = "R9"; r = a | ~b; end
    else if (opc == 7'b0110011 && f7 == 7'b0100000 && f3 == 3'b111) begin tag = "R9"; r = a & ~b; end
    else v = 1'b0;
    return {v, r};
  endfunction

  task automatic run(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
      input logic [4:0] fl, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] exp; string tag;
    @(negedge clk);
    in_major = opc; in_fn3 = f3; in_fn7 = f7; in_sel5 = fl; in_a = a; in_b = b;
    exp = ref_model(opc, f3, f7, fl, a, b, tag);
    @(negedge clk);
    checks++;
    if (out_valid !== exp[32] || out_result !== exp[31:0]) begin
      errors++;
      $display("FAIL %s op=%b f3=%b f7=%b fld=%b a=%h b=%h: got valid=%0b result=%h, expected valid=%0b result=%h",
               tag, opc, f3, f7, fl, a, b, out_valid, out_result, exp[32], exp[31:0]);
    end
  endtask

  task automatic check_cleared(input string what);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'h0) begin
      errors++;
      $display("FAIL R11 %s: got valid=%0b result=%h, expected valid=0 result=00000000",
               what, out_valid, out_result);
    end
  endtask

  function automatic logic [21:0] enc(input int k);
    case (k)
      0:  return {7'b0010011, 3'b001, 7'b0010100, 5'd3};
      1:  return {7'b0010011, 3'b001, 7'b0100100, 5'd9};
      2:  return {7'b0010011, 3'b001, 7'b0110100, 5'd17};
      3:  return {7'b0010011, 3'b001, 7'b0110000, 5'd0};
      4:  return {7'b0010011, 3'b001, 7'b0110000, 5'd1};
      5:  return {7'b0010011, 3'b001, 7'b0110000, 5'd2};
      6:  return {7'b0010011, 3'b001, 7'b0110000, 5'd4};
      7:  return {7'b0010011, 3'b001, 7'b0110000, 5'd5};
      8:  return {7'b0010011, 3'b101, 7'b0100100, 5'd6};
      9:  return {7'b0010011, 3'b101, 7'b0110000, 5'd11};
      10: return {7'b0010011, 3'b101, 7'b0010100, 5'd7};
      11: return {7'b0010011, 3'b101, 7'b0110100, 5'd24};
      12: return {7'b0110011, 3'b001, 7'b0010100, 5'd2};
      13: return {7'b0110011, 3'b001, 7'b0100100, 5'd2};
      14: return {7'b0110011, 3'b001, 7'b0110000, 5'd2};
      15: return {7'b0110011, 3'b001, 7'b0110100, 5'd2};
      16: return {7'b0110011, 3'b010, 7'b0010000, 5'd2};
      17: return {7'b0110011, 3'b100, 7'b0010000, 5'd2};
      18: return {7'b0110011, 3'b110, 7'b0010000, 5'd2};
      19: return {7'b0110011, 3'b100, 7'b0000101, 5'd2};
      20: return {7'b0110011, 3'b101, 7'b0000101, 5'd2};
      21: return {7'b0110011, 3'b110, 7'b0000101, 5'd2};
      22: return {7'b0110011, 3'b111, 7'b0000101, 5'd2};
      23: return {7'b0110011, 3'b100, 7'b0100000, 5'd2};
      24: return {7'b0110011, 3'b110, 7'b0100000, 5'd2};
      25: return {7'b0110011, 3'b111, 7'b0100000, 5'd2};
      26: return {7'b0110011, 3'b100, 7'b0000100, 5'd0};
      27: return {7'b0110011, 3'b101, 7'b0100100, 5'd2};
      default: return {7'b0110011, 3'b101, 7'b0110000, 5'd2};
    endcase
  endfunction

  function automatic logic [63:0] operands(input int k);
    case (k)
      0: return {32'h00000000, 32'h00000000};
      1: return {32'hFFFFFFFF, 32'h00000000};
      2: return {32'h80000000, 32'h0000001F};
      3: return {32'h00000001, 32'hFFFFFFFF};
      4: return {32'h7FFFFFFF, 32'h80000000};
      5: return {32'h0000FF80, 32'h00000020};
      6: return {32'h00008000, 32'hFFFFFFE5};
      7: return {32'h00FF0000, 32'h00000003};
      default: return {32'(k) * 32'h9E3779B9 ^ 32'(k << 11), 32'(k * k) * 32'h85EBCA6B + 32'h1234};
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [21:0] e;
    logic [63:0] ab;
    // R11: reset state while a valid encoding is presented
    in_major = 7'b0110011; in_fn3 = 3'b111; in_fn7 = 7'b0000101; in_a = 32'h5; in_b = 32'h9;
    repeat (3) @(negedge clk);
    check_cleared("during reset");
    rst = 1'b0;

    // R10 and all decode requirements: field sweep with fixed operands
    for (int o = 0; o < 3; o++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int f7 = 0; f7 < 128; f7++)
          for (int s = 0; s < 9; s++) begin
            logic [6:0] opc;
            logic [4:0] fl;
            opc = (o == 0) ? 7'b0010011 : (o == 1) ? 7'b0110011 : 7'b0111011;
            case (s)
              0: fl = 5'd0; 1: fl = 5'd1; 2: fl = 5'd2; 3: fl = 5'd3; 4: fl = 5'd4;
              5: fl = 5'd5; 6: fl = 5'd7; 7: fl = 5'd24; default: fl = 5'd31;
            endcase
            run(opc, 3'(f3), 7'(f7), fl, 32'h00F0_1230, 32'h0000_0013);
          end

    // R1-R9: every supported encoding against edge and spread operands
    for (int k = 0; k < 29; k++)
      for (int p = 0; p < 40; p++) begin
        e = enc(k); ab = operands(p);
        run(e[21:15], e[14:12], e[11:5], e[4:0], ab[63:32], ab[31:0]);
      end

    // R1 R2 R5: every bit index and rotate amount, with junk in upper bits of b
    for (int i = 0; i < 32; i++) begin
      run(7'b0010011, 3'b001, 7'b0010100, 5'd0, 32'h0, 32'(i) | 32'hABCD_E000);
      run(7'b0110011, 3'b101, 7'b0100100, 5'd0, 32'hA5A5_0F0F, 32'(i) | 32'hFFFF_FF00);
      run(7'b0110011, 3'b001, 7'b0110000, 5'd0, 32'h8000_0003, 32'(i) | 32'h0000_0F60);
      run(7'b0010011, 3'b101, 7'b0110000, 5'd0, 32'h1234_5678, 32'(i) | 32'h8000_0000);
    end

    // R11: reset in mid-run clears the registered outputs
    run(7'b0110011, 3'b111, 7'b0000101, 5'd0, 32'h10, 32'h20);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); check_cleared("after mid-run reset");
    rst = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule